// File: doc/BRIEF.md
# Programmable DRAM Refresh Request Generator

This block decides when a dynamic memory needs a refresh cycle and which row that cycle should touch. Software programs a single 16-bit control word. The word holds a run bit, an interval code and the row address for the next refresh. A timer with a fixed divide-by-four stage counts out the programmed interval. Each time the interval runs out, the block raises a request towards the bus arbiter.

The request stays up until the arbiter answers with a grant. While a refresh is in progress the block presents the current row on its row output. When the grant is accepted, the row advances by one. If the arbiter is slow, one further expiry is remembered, so no more than two refreshes are ever owed. A write to the control word restarts the interval timer. A write that clears the run bit stops the timer and discards anything owed. RAS/CAS sequencing, arbitration and the memory itself belong to neighbouring blocks.

Top module: `rfsh_engine`

## Requirements
- R1: After reset the control word reads 0x0000 and `refReq` is low.
- R2: A value written through `regWrEn`/`regWrData` reads back on `regRdData` from the next cycle on. The word is laid out as: bit 15 is the run bit, bits 14:9 are the interval code N, and bits 8:0 are the row.
- R3: When the run bit is 1 and N is nonzero, `refReq` rises exactly 4×N clock cycles after the write edge (N=16 gives 64 cycles).
- R4: An interval code of 0 behaves as 64, giving a 256-cycle interval.
- R5: Once raised, `refReq` stays high until a cycle with `refGrant` high. After a grant with one refresh owed, it is low in the next cycle.
- R6: `refRow` always shows bits 8:0 of the control word. Each accepted grant (`refGrant` and `refReq` both high at a clock edge) adds one to the row, and the row wraps from 511 to 0.
- R7: A `refGrant` while `refReq` is low has no effect: the row and the request are unchanged.
- R8: At most two refreshes are owed. Three expiries without a grant need two grants to clear `refReq`.
- R9: A write with the run bit at 0 clears `refReq` from the next cycle. While the run bit is 0, no request is raised.
- R10: Any write to the control word restarts the interval, so the next request comes 4×N cycles after the latest write.
- R11: The timer runs freely across grants. With grants always available, requests come every 4×N cycles, and each lasts for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regWrData | input | 16 | Control word write value |
| regRdData | output | 16 | Current control word |
| refReq | output | 1 | Refresh request to the arbiter |
| refGrant | input | 1 | Grant from the arbiter |
| refRow | output | 9 | Row address for the refresh cycle |

## Verification
The checker watches several rules on every cycle:
- the row moves by exactly one on each accepted grant and is otherwise steady;
- a write reads back;
- a request holds until granted;
- a cleared run bit forces the request low.

The exact interval lengths can only be shown by the bench's scenarios: 4×N cycles, 256 cycles for a zero code, and the restart after a write. The same holds for the two-deep saturation of owed refreshes and for the wrap of the row from 511 to 0.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  // Strobes from the control part to the datapath part
  typedef struct packed {
    logic load;    // control word written this cycle
    logic advRow;  // accepted grant: move to the next row
  } rfshStrobe_t;
endpackage

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
#(
  parameter int RATE_W   = 6,
  parameter int PRESCALE = 4,
  parameter int MAX_PEND = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate,
  input  logic              wrEn,
  input  logic              wrRunBit,
  input  logic              grant,
  output logic              refReq,
  output rfshStrobe_t       strobe
);
  localparam int PRE_W  = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam int INT_W  = RATE_W + 1;
  localparam int PEND_W = $clog2(MAX_PEND + 1);

  logic [PRE_W-1:0]  preCnt;
  logic [INT_W-1:0]  intCnt;
  logic [INT_W-1:0]  rateLimit;
  logic [PEND_W-1:0] pendCnt;
  logic              preWrap;
  logic              intWrap;
  logic              expire;
  logic              accept;
  logic              pendInc;

  // A zero code stands for the largest interval
  always_comb begin
    rateLimit = (rate == '0) ? INT_W'(1 << RATE_W) : INT_W'(rate);
  end

  assign preWrap = (preCnt == PRE_W'(PRESCALE - 1));
  assign intWrap = (intCnt == rateLimit - INT_W'(1));
  assign expire  = enable && preWrap && intWrap;
  assign accept  = grant && refReq;
  assign pendInc = expire && !wrEn;

  always_ff @(posedge clk) begin
    if (!rst_n || wrEn || !enable) begin
      preCnt <= '0;
      intCnt <= '0;
    end else begin
      preCnt <= preWrap ? '0 : preCnt + PRE_W'(1);
      if (preWrap) begin
        intCnt <= intWrap ? '0 : intCnt + INT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || (wrEn && !wrRunBit)) begin
      pendCnt <= '0;
    end else if (pendInc && !accept) begin
      if (pendCnt != PEND_W'(MAX_PEND)) begin
        pendCnt <= pendCnt + PEND_W'(1);
      end
    end else if (accept && !pendInc) begin
      pendCnt <= pendCnt - PEND_W'(1);
    end
  end

  assign refReq        = (pendCnt != '0);
  assign strobe.load   = wrEn;
  assign strobe.advRow = accept;
endmodule

// File: rtl/rfsh_data.sv
module rfsh_data
  import rfsh_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int RATE_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  rfshStrobe_t               strobe,
  input  logic [ROW_W+RATE_W:0]     wrData,
  output logic                      enable,
  output logic [RATE_W-1:0]         rate,
  output logic [ROW_W-1:0]          row,
  output logic [ROW_W+RATE_W:0]     regValue
);
  localparam int REG_W = 1 + RATE_W + ROW_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
      rate   <= '0;
      row    <= '0;
    end else if (strobe.load) begin
      enable <= wrData[REG_W-1];
      rate   <= wrData[ROW_W +: RATE_W];
      row    <= wrData[ROW_W-1:0];
    end else if (strobe.advRow) begin
      row <= row + ROW_W'(1);
    end
  end

  assign regValue = {enable, rate, row};
endmodule

// File: rtl/rfsh_engine.sv
module rfsh_engine
  import rfsh_pkg::*;
#(
  parameter int ROW_W    = 9,
  parameter int RATE_W   = 6,
  parameter int PRESCALE = 4,
  parameter int MAX_PEND = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  regWrEn,
  input  logic [ROW_W+RATE_W:0] regWrData,
  output logic [ROW_W+RATE_W:0] regRdData,
  output logic                  refReq,
  input  logic                  refGrant,
  output logic [ROW_W-1:0]      refRow
);
  localparam int REG_W = 1 + RATE_W + ROW_W;

  rfshStrobe_t       strobe;
  logic              enable;
  logic [RATE_W-1:0] rate;

  rfsh_ctrl #(.RATE_W(RATE_W), .PRESCALE(PRESCALE), .MAX_PEND(MAX_PEND)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .rate     (rate),
    .wrEn     (regWrEn),
    .wrRunBit (regWrData[REG_W-1]),
    .grant    (refGrant),
    .refReq   (refReq),
    .strobe   (strobe)
  );

  rfsh_data #(.ROW_W(ROW_W), .RATE_W(RATE_W)) uData (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wrData   (regWrData),
    .enable   (enable),
    .rate     (rate),
    .row      (refRow),
    .regValue (regRdData)
  );
endmodule

// File: rtl/rfsh_engine_chk.sv
module rfsh_engine_chk #(
  parameter int ROW_W  = 9,
  parameter int RATE_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  regWrEn,
  input logic [ROW_W+RATE_W:0] regWrData,
  input logic [ROW_W+RATE_W:0] regRdData,
  input logic                  refReq,
  input logic                  refGrant,
  input logic [ROW_W-1:0]      refRow
);
  localparam int REG_W = 1 + RATE_W + ROW_W;

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> regRdData == $past(regWrData)); // R2

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (refReq && !refGrant && !(regWrEn && !regWrData[REG_W-1])) |=> refReq); // R5

  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (refGrant && refReq && !regWrEn) |=> refRow == ROW_W'($past(refRow) + 1'b1)); // R6

  AST_ROW_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!regWrEn && !(refGrant && refReq)) |=> $stable(refRow)); // R7

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && !regWrData[REG_W-1]) |=> !refReq); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!regRdData[REG_W-1] && !regWrEn) |=> !refReq); // R9
endmodule

bind rfsh_engine rfsh_engine_chk #(.ROW_W(ROW_W), .RATE_W(RATE_W)) chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .refReq    (refReq),
  .refGrant  (refGrant),
  .refRow    (refRow)
);

// File: tb/rfsh_engine_test.sv
`timescale 1ns/1ps
module rfsh_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        refReq;
  logic        refGrant = 1'b0;
  logic [8:0]  refRow;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  rfsh_engine uut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .refReq(refReq), .refGrant(refGrant), .refRow(refRow)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input bit run, input int n, input int row);
    return {run, 6'(n), 9'(row)};
  endfunction

  task automatic writeReg(input logic [15:0] d);
    @(negedge clk);
    regWrEn   = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Counts clock edges since the last write until refReq is seen high
  task automatic waitReq(input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!refReq && n < limit);
  endtask

  task automatic pulseGrant();
    @(negedge clk);
    refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
  endtask

  task automatic testReset();
    check("R1 read after reset", regRdData, 0);
    check("R1 request after reset", refReq, 0);
  endtask

  task automatic testReadback();
    writeReg(16'h1234);
    check("R2 readback", regRdData, 16'h1234);
    check("R6 row shows field", refRow, 9'h034);
  endtask

  task automatic testInterval();
    int n;
    writeReg(word(1, 16, 5));
    waitReq(1000, n);
    check("R3 interval for code 16", n, 64);
    check("R6 row during refresh", refRow, 5);
    repeat (10) @(posedge clk);
    #1 check("R5 request held", refReq, 1);
    pulseGrant();
    check("R5 request dropped after grant", refReq, 0);
    check("R6 row advanced", refRow, 6);
    writeReg(word(0, 0, 0));
  endtask

  task automatic testZeroCode();
    int n;
    writeReg(word(1, 0, 0));
    waitReq(1000, n);
    check("R4 interval for code 0", n, 256);
    writeReg(word(0, 0, 0));
  endtask

  task automatic testPeriodic();
    int highs = 0;
    int offBeat = 0;
    @(negedge clk) refGrant = 1'b1;
    writeReg(word(1, 2, 0));
    for (int n = 1; n <= 32; n++) begin
      @(posedge clk); #1;
      if (refReq) begin
        highs++;
        if (n % 8 != 0) offBeat++;
      end else if (n % 8 == 0) begin
        offBeat++;
      end
    end
    check("R11 request count in 32 cycles", highs, 4);
    check("R11 requests off the 8-cycle beat", offBeat, 0);
    check("R11 row after three grants", refRow, 3);
    @(negedge clk) refGrant = 1'b0;
    writeReg(word(0, 0, 0));
  endtask

  task automatic testWrap();
    int n;
    writeReg(word(1, 1, 511));
    waitReq(100, n);
    check("R3 interval for code 1", n, 4);
    pulseGrant();
    check("R6 row wrap", refRow, 0);
    check("R5 request cleared after wrap grant", refReq, 0);
    writeReg(word(0, 0, 0));
  endtask

  task automatic testIgnoredGrant();
    writeReg(word(0, 0, 100));
    pulseGrant();
    check("R7 row unchanged by stray grant", refRow, 100);
    check("R7 no request from stray grant", refReq, 0);
    check("R7 word unchanged", regRdData, word(0, 0, 100));
  endtask

  task automatic testQueue();
    int n;
    writeReg(word(1, 1, 10));
    waitReq(100, n);
    check("R8 first expiry", n, 4);
    repeat (9) @(posedge clk);
    #1;
    @(negedge clk) refGrant = 1'b1;
    @(posedge clk); #1;
    check("R8 still owed after first grant", refReq, 1);
    check("R8 row after first grant", refRow, 11);
    @(posedge clk); #1;
    check("R8 cleared after second grant", refReq, 0);
    check("R8 row after second grant", refRow, 12);
    @(negedge clk) refGrant = 1'b0;
    writeReg(word(0, 0, 0));
  endtask

  task automatic testStop();
    int n;
    int highs = 0;
    writeReg(word(1, 1, 0));
    waitReq(100, n);
    check("R9 request before stop", refReq, 1);
    writeReg(word(0, 1, 0));
    check("R9 request dropped by stop", refReq, 0);
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      if (refReq) highs++;
    end
    check("R9 requests while stopped", highs, 0);
    check("R9 readback after stop", regRdData, word(0, 1, 0));
  endtask

  task automatic testReload();
    int n;
    writeReg(word(1, 4, 0));
    repeat (10) @(posedge clk);
    writeReg(word(1, 4, 0));
    waitReq(100, n);
    check("R10 interval restarts on write", n, 16);
    writeReg(word(0, 0, 0));
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    testReset();
    testReadback();
    testInterval();
    testZeroCode();
    testPeriodic();
    testWrap();
    testIgnoredGrant();
    testQueue();
    testStop();
    testReload();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule